// File: doc/BRIEF.md
# Self-Repairing Twisted-Ring Counter

This block is a Johnson (twisted-ring) counter of parameterised width N. It steps through 2N states in which the ones fill in from the low end and then drain out from the low end. On each enabled clock, stage 0 takes the inverse of the top stage, and every other stage takes the value of the stage below it. Because decoding any one of its states needs only two adjacent bits, it is often used as a glitch-free phase generator. Its weakness is that a bit upset by noise or a bad power-up would otherwise circulate forever.

To remove that weakness, one fixed stage (CORR_STAGE) is fed through a small repair cell. The cell looks at a window of three adjacent stages: CORR_STAGE-2, CORR_STAGE-1 and CORR_STAGE itself. When that window reads 0,1,0, the cell loads an inverted copy of the middle bit into CORR_STAGE. In every other case the middle bit passes through unchanged. The opposite error shape, 1,0,1, is left alone. It travels to the top of the ring, is inverted by the twist, and comes back around as 0,1,0, where the cell then removes it. Each time the cell acts, a one-cycle flag is raised.

A load path lets a test write any value into the ring, including corrupted ones. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `jc_selfheal_ring`

## Requirements
- R1: While reset is held, and until the first enabled update after it, `ring` is all zeros and `fix_pulse` is low.
- R2: With `en` high and `force_load` low, each clock sets bit 0 to the inverse of bit N-1, and sets every bit i other than bit 0 and bit CORR_STAGE to the old bit i-1. From all zeros, a legal ring repeats with a period of exactly 2N clocks.
- R3: With `en` low and `force_load` low, `ring` holds its value and `fix_pulse` is low on the next cycle.
- R4: With `force_load` high, the next clock loads `force_value` into `ring` whatever `en` is, and `fix_pulse` is low on the next cycle.
- R5: On an enabled step, if bit CORR_STAGE-2 is 0, bit CORR_STAGE-1 is 1 and bit CORR_STAGE is 0, then bit CORR_STAGE receives 0. Otherwise it receives the old bit CORR_STAGE-1.
- R6: A legal state is one whose bits change value at most once going from bit 0 to bit N-1 (there are 2N of them). An enabled step from a legal state always gives a legal state, with no repair applied.
- R7: Start from any legal state with exactly one bit flipped. Within 2N+1 enabled steps the ring reaches a legal state and stays legal from then on.
- R8: `fix_pulse` is high for the one cycle that follows an enabled step on which the R5 repair inverted the shifted bit, and it is low on all other cycles.
- R9: A 1,0,1 pattern in the window is not repaired. The step shifts the middle bit through unchanged and `fix_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| en | input | 1 | Count enable: one ring step per clock while high |
| force_load | input | 1 | Test load: writes `force_value` into the ring, overriding `en` |
| force_value | input | N | Value written by a test load |
| ring | output | N | Counter state, bit 0 is the stage fed by the inverted top stage |
| fix_pulse | output | 1 | High for one cycle after a step that applied a repair |

## Verification
The ring register drives the output port directly, so any wrong internal state shows up on `ring` in the same cycle it is stored. A wrong next-state term therefore shows up one clock after the step that used it. An error in the repair cell appears in one of two ways: as a `ring` value that fails the at-most-one-transition test, or as a `fix_pulse` that disagrees with the window the bench saw one clock earlier. A missing repair would leave a corrupted pattern circulating, and that is visible as a recovery that has not finished after 2N+1 steps. Loading every single-flip state through the test port covers every position at which an error can enter the ring.

// File: rtl/jc_pkg.sv
package jc_pkg;

  // What the ring register does on the coming clock edge
  typedef enum logic [1:0] {
    JC_HOLD = 2'd0,
    JC_STEP = 2'd1,
    JC_LOAD = 2'd2
  } jc_op_e;

  // A window value that no legal ring can contain and that the repair cell removes
  localparam logic [2:0] JC_BAD_WIN = 3'b010;

endpackage

// File: rtl/jc_rst_sync.sv
module jc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/jc_window_fix.sv
module jc_window_fix
  import jc_pkg::*;
(
  input  logic [2:0] win,       // [0] upstream, [1] middle, [2] downstream
  output logic       shift_bit, // value passed on to the downstream stage
  output logic       repaired
);

  always_comb begin
    repaired  = (win == JC_BAD_WIN);
    shift_bit = repaired ? ~win[1] : win[1];
  end

endmodule

// File: rtl/jc_next_state.sv
module jc_next_state
  import jc_pkg::*;
#(
  parameter int N          = 4,
  parameter int CORR_STAGE = 2
) (
  input  logic [N-1:0] cur,
  input  jc_op_e       op,
  input  logic [N-1:0] load_value,
  output logic [N-1:0] nxt,
  output logic         fix
);

  logic [N-1:0] stepped;
  logic         win_shift;
  logic         win_hit;

  jc_window_fix u_fix (
    .win      (cur[CORR_STAGE:CORR_STAGE-2]),
    .shift_bit(win_shift),
    .repaired (win_hit)
  );

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_twist
      assign stepped[i] = ~cur[N-1];
    end else if (i == CORR_STAGE) begin : g_repair
      assign stepped[i] = win_shift;
    end else begin : g_plain
      assign stepped[i] = cur[i-1];
    end
  end

  always_comb begin
    nxt = cur;
    fix = 1'b0;
    unique case (op)
      JC_STEP: begin
        nxt = stepped;
        fix = win_hit;
      end
      JC_LOAD: nxt = load_value;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/jc_selfheal_ring.sv
module jc_selfheal_ring
  import jc_pkg::*;
#(
  parameter int N          = 4,
  parameter int CORR_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         force_load,
  input  logic [N-1:0] force_value,
  output logic [N-1:0] ring,
  output logic         fix_pulse
);

  if (CORR_STAGE < 2 || CORR_STAGE > N - 1) begin : g_bad_param
    $error("CORR_STAGE must lie in 2..N-1");
  end

  logic         rst_sync_n;
  jc_op_e       op;
  logic [N-1:0] ring_q;
  logic [N-1:0] ring_d;
  logic         fix_d;
  logic         fix_q;

  jc_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sync_n)
  );

  always_comb begin
    if (force_load) begin
      op = JC_LOAD;
    end else if (en) begin
      op = JC_STEP;
    end else begin
      op = JC_HOLD;
    end
  end

  jc_next_state #(.N(N), .CORR_STAGE(CORR_STAGE)) u_next (
    .cur       (ring_q),
    .op        (op),
    .load_value(force_value),
    .nxt       (ring_d),
    .fix       (fix_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ring_q <= '0;
    end else if (op != JC_HOLD) begin
      ring_q <= ring_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fix_q <= 1'b0;
    end else begin
      fix_q <= fix_d;
    end
  end

  assign ring      = ring_q;
  assign fix_pulse = fix_q;

endmodule

// File: rtl/jc_selfheal_ring_chk.sv
module jc_selfheal_ring_chk #(
  parameter int N          = 4,
  parameter int CORR_STAGE = 2
) (
  input logic         clk,
  input logic         srst_n,
  input logic         en,
  input logic         force_load,
  input logic [N-1:0] force_value,
  input logic [N-1:0] ring,
  input logic         fix_pulse
);

  function automatic bit legal(input logic [N-1:0] v);
    int edges = 0;
    for (int i = 0; i < N - 1; i++) begin
      if (v[i] != v[i+1]) edges++;
    end
    return edges <= 1;
  endfunction

  logic step_now;
  logic bad_win;
  assign step_now = en && !force_load;
  assign bad_win  = (ring[CORR_STAGE-2] == 1'b0) && (ring[CORR_STAGE-1] == 1'b1) &&
                    (ring[CORR_STAGE] == 1'b0);

  // R1: while the synchronised reset is low the ring is cleared
  p_reset_clear_r1: assert property (@(posedge clk) !srst_n |=> (ring == '0) || !$past(srst_n) && srst_n);

  p_twist_r2: assert property (@(posedge clk) disable iff (!srst_n)
    step_now |=> ring[0] == ~$past(ring[N-1]));

  p_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (!en && !force_load) |=> $stable(ring) && !fix_pulse);

  p_load_r4: assert property (@(posedge clk) disable iff (!srst_n)
    force_load |=> (ring == $past(force_value)) && !fix_pulse);

  p_repair_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (step_now && bad_win) |=> !ring[CORR_STAGE]);

  p_legal_kept_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (step_now && legal(ring)) |=> legal(ring) && !fix_pulse);

  p_fix_cause_r8: assert property (@(posedge clk) disable iff (!srst_n)
    fix_pulse |-> $past(step_now) && $past(bad_win));

  p_fix_seen_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (step_now && bad_win) |=> fix_pulse);

  p_no_repair_101_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (step_now && ring[CORR_STAGE-2] && !ring[CORR_STAGE-1] && ring[CORR_STAGE])
      |=> !fix_pulse && !ring[CORR_STAGE]);

endmodule

bind jc_selfheal_ring jc_selfheal_ring_chk #(.N(N), .CORR_STAGE(CORR_STAGE)) u_chk (
  .clk        (clk),
  .srst_n     (rst_sync_n),
  .en         (en),
  .force_load (force_load),
  .force_value(force_value),
  .ring       (ring),
  .fix_pulse  (fix_pulse)
);

// File: tb/tb_jc_selfheal_ring.sv
`timescale 1ns/1ps
module tb_jc_selfheal_ring;

  localparam int N  = 4;
  localparam int CS = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic         force_load;
  logic [N-1:0] force_value;
  logic [N-1:0] ring;
  logic         fix_pulse;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_ring;
  logic         m_fix;

  always #2.5 clk = ~clk;

  jc_selfheal_ring #(.N(N), .CORR_STAGE(CS)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .force_load(force_load),
    .force_value(force_value), .ring(ring), .fix_pulse(fix_pulse)
  );

  task automatic chk_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ring actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic bit is_legal(logic [N-1:0] v);
    int edges = 0;
    for (int i = 0; i < N - 1; i++) if (v[i] != v[i+1]) edges++;
    return edges <= 1;
  endfunction

  function automatic logic [N-1:0] legal_state(int k);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (k <= N) ? (i < k) : (i >= k - N);
    return v;
  endfunction

  // Behavioural model: the ring is a queue of bits, index 0 = bit 0
  task automatic model_update(bit e, bit f, logic [N-1:0] fv);
    bit q[$];
    bit hit;
    if (f) begin
      m_ring = fv;
      m_fix  = 1'b0;
    end else if (e) begin
      for (int i = 0; i < N; i++) q.push_back(m_ring[i]);
      hit = (q[CS-2] == 1'b0) && (q[CS-1] == 1'b1) && (q[CS] == 1'b0);
      q.push_front(~q[N-1]);
      q.delete(N);
      if (hit) q[CS] = 1'b0;
      for (int i = 0; i < N; i++) m_ring[i] = q[i];
      m_fix = hit;
    end else begin
      m_fix = 1'b0;
    end
  endtask

  task automatic cycle(bit e, bit f, logic [N-1:0] fv, string req);
    en = e; force_load = f; force_value = fv;
    @(posedge clk);
    model_update(e, f, fv);
    @(negedge clk);
    chk_vec(req, ring, m_ring);
    chk_bit({req, " fix_pulse"}, fix_pulse, m_fix);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    logic [N-1:0] start;
    rst_n = 1'b0; en = 1'b0; force_load = 1'b0; force_value = '0;
    m_ring = '0; m_fix = 1'b0;
    repeat (3) @(negedge clk);
    // R1: cleared in reset
    chk_vec("R1 reset", ring, '0);
    chk_bit("R1 reset fix_pulse", fix_pulse, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, '0, "R1 release");

    // R2, R6: legal counting and its period
    start = ring;
    for (int i = 0; i < 3 * 2 * N; i++) begin
      cycle(1'b1, 1'b0, '0, "R2 step");
      chk_bit("R6 legal while counting", is_legal(ring), 1'b1);
      if ((i + 1) % (2 * N) == 0) chk_vec("R2 period 2N", ring, start);
      if (i == 2 * N - 1) chk_vec("R2 period not shorter", ring, start);
    end

    // R3: hold
    for (int k = 1; k < 2 * N; k += 3) begin
      cycle(1'b0, 1'b1, legal_state(k), "R4 load legal");
      start = ring;
      for (int i = 0; i < 3; i++) begin
        cycle(1'b0, 1'b0, ~start, "R3 hold");
        chk_vec("R3 hold unchanged", ring, start);
      end
    end

    // R4: load overrides enable
    cycle(1'b1, 1'b1, 4'b0110, "R4 load with en");
    chk_vec("R4 load value", ring, 4'b0110);
    cycle(1'b0, 1'b1, 4'b1001, "R4 load without en");
    chk_vec("R4 load value", ring, 4'b1001);

    // R9 then R5/R8: 1101 -> 1010 (no repair) -> 0000 (repair, flag)
    cycle(1'b0, 1'b1, 4'b1101, "R9 setup");
    cycle(1'b1, 1'b0, '0, "R9 step");
    chk_vec("R9 101 not repaired", ring, 4'b1010);
    chk_bit("R9 no flag", fix_pulse, 1'b0);
    cycle(1'b1, 1'b0, '0, "R5 step");
    chk_vec("R5 010 repaired", ring, 4'b0000);
    chk_bit("R8 flag raised", fix_pulse, 1'b1);
    cycle(1'b1, 1'b0, '0, "R8 step");
    chk_bit("R8 flag one cycle", fix_pulse, 1'b0);

    // R7: every single-bit corruption of every legal state recovers
    for (int k = 0; k < 2 * N; k++) begin
      for (int b = 0; b < N; b++) begin
        int steps_taken;
        logic [N-1:0] bad;
        bad = legal_state(k);
        bad[b] = ~bad[b];
        cycle(1'b0, 1'b1, bad, "R7 load corrupted");
        steps_taken = 0;
        while (!is_legal(ring) && steps_taken <= 2 * N + 1) begin
          cycle(1'b1, 1'b0, '0, "R7 recover step");
          steps_taken++;
        end
        checks++;
        if (!is_legal(ring) || steps_taken > 2 * N + 1) begin
          errors++;
          $display("FAIL R7 state %b actual steps %0d expected at most %0d",
                   bad, steps_taken, 2 * N + 1);
        end
        for (int i = 0; i < 2 * N; i++) begin
          cycle(1'b1, 1'b0, '0, "R6 after recovery");
          chk_bit("R6 stays legal", is_legal(ring), 1'b1);
          chk_bit("R8 no flag when legal", fix_pulse, 1'b0);
        end
      end
    end

    finish_run();
  end

endmodule